// File: doc/BRIEF.md
# ADC Emulation Pattern Player

This block stands in for the eight 12-bit ADC channels of an analog front end. It lets the downstream processing chain run on known data when no analog hardware is fitted. Each channel's 12-bit slot in the 96-bit sample word can come from one of four places:

- the live converter input;
- a 512-entry pattern buffer that the host loads;
- a fixed test constant;
- a free-running test counter.

A separate 512-entry pulse buffer holds one bit per channel. It plays out alongside the pattern buffer and gives an 8-bit vector of analog-pulse triggers.

A single play control decides who owns both buffers. While play is low, the host port writes and reads them. While play is high, both buffers are read one entry per sample clock, in lockstep, and any host access is ignored. The buffers are modelled as single-clock memories in the sample clock domain.

Top module: `adc_emu_player`

## Requirements
- R1: While rst_ni is low, sample_o, pulse_o and host_rdata_o are all zero.
- R2: Channel c uses sample_o bits [12c+11:12c] and select bits src_sel_i[2c+1:2c]. The select codes are 0 = live (adc_live_i slice), 1 = pattern, 2 = fixed, 3 = counter. Outputs are registered, so the value shows one clock after its inputs.
- R3: A fixed slot carries 0x456 on even channels and 0xABC on odd channels.
- R4: A counter slot shows a counter that starts at 0 on the first clock after reset and advances every clock. Even channels use a counter that wraps from 4095 to 0. Odd channels use one that wraps from 2047 to 0.
- R5: On every clock with play_i high, the pattern slots take the current pattern entry and pulse_o takes the pulse entry at the same index. The index is 0 on the first playing clock, rises by one per clock, and wraps from 511 to 0.
- R6: On a clock with play_i low, pattern slots give 0, pulse_o gives 0, and the playout index returns to 0.
- R7: With play_i low, host_wr_i stores host_wdata_i at host_addr_i. host_sel_i = 0 selects the pattern buffer (96 bits). host_sel_i = 1 selects the pulse buffer (bits [7:0]).
- R8: With play_i low, host_rd_i returns the addressed entry on host_rdata_o one clock later. Pulse entries are zero-extended. On a clock without a read, host_rdata_o is zero the next cycle.
- R9: With play_i high, host writes leave both buffers unchanged and host reads return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| play_i | input | 1 | 1: buffers play out at sample rate; 0: host owns buffers |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read strobe |
| host_sel_i | input | 1 | Buffer select: 0 pattern, 1 pulse |
| host_addr_i | input | 9 | Host entry address |
| host_wdata_i | input | 96 | Host write data |
| host_rdata_o | output | 96 | Host read data, one clock after the read |
| adc_live_i | input | 96 | Live converter samples, 12 bits per channel |
| src_sel_i | input | 16 | Per-channel 2-bit source select |
| sample_o | output | 96 | Emulated sample word |
| pulse_o | output | 8 | Per-channel analog-pulse trigger |

## Verification
The hardest cases to reach are the two long wraps: the playout index going from 511 to 0, and the even-channel counter going from 4095 to 0. Neither can be forced from the ports. The stimulus therefore fills every pattern and pulse entry through the host port, then holds play high for more than 512 clocks. After that it holds counter mode for more than 4096 clocks, while the bench model counts clocks from reset release. A further case drives host writes and reads while play is high, then reads the same entry back after play drops. This shows through the host port that the stored data is unchanged.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;
  typedef enum logic [1:0] {
    SRC_LIVE    = 2'd0,
    SRC_PATTERN = 2'd1,
    SRC_FIXED   = 2'd2,
    SRC_COUNT   = 2'd3
  } src_e;
endpackage

// File: rtl/emu_buf.sv
// Single-port-address buffer: one write port, one asynchronous read port.
module emu_buf #(
  parameter int W     = 96,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/emu_cnt.sv
module emu_cnt #(
  parameter int W   = 12,
  parameter int MAX = 4095
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (cnt_q == W'(MAX))  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/emu_chan_mux.sv
module emu_chan_mux
  import adc_emu_pkg::*;
#(
  parameter int          DW  = 12,
  parameter logic [11:0] FIX = 12'h456
) (
  input  logic [1:0]    sel_i,
  input  logic [DW-1:0] live_i,
  input  logic [DW-1:0] pat_i,
  input  logic [DW-1:0] cnt_i,
  output logic [DW-1:0] slot_o
);
  always_comb begin
    unique case (src_e'(sel_i))
      SRC_LIVE:    slot_o = live_i;
      SRC_PATTERN: slot_o = pat_i;
      SRC_FIXED:   slot_o = DW'(FIX);
      default:     slot_o = cnt_i;
    endcase
  end
endmodule

// File: rtl/adc_emu_player.sv
module adc_emu_player #(
  parameter int          NCH          = 8,
  parameter int          DW           = 12,
  parameter int          DEPTH        = 512,
  parameter logic [11:0] FIX_EVEN     = 12'h456,
  parameter logic [11:0] FIX_ODD      = 12'hABC,
  parameter int          CNT_MAX_EVEN = 4095,
  parameter int          CNT_MAX_ODD  = 2047,
  localparam int         AW           = $clog2(DEPTH),
  localparam int         SW           = NCH * DW,
  localparam int         SELW         = 2 * NCH
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            play_i,
  input  logic            host_wr_i,
  input  logic            host_rd_i,
  input  logic            host_sel_i,
  input  logic [AW-1:0]   host_addr_i,
  input  logic [SW-1:0]   host_wdata_i,
  output logic [SW-1:0]   host_rdata_o,
  input  logic [SW-1:0]   adc_live_i,
  input  logic [SELW-1:0] src_sel_i,
  output logic [SW-1:0]   sample_o,
  output logic [NCH-1:0]  pulse_o
);
  logic [AW-1:0]  play_ptr;
  logic [AW-1:0]  buf_raddr;
  logic [SW-1:0]  pat_rd;
  logic [NCH-1:0] pul_rd;
  logic [SW-1:0]  pat_slot;
  logic [SW-1:0]  sample_d;
  logic [DW-1:0]  cnt_full;
  logic [DW-1:0]  cnt_half;
  logic           pat_we;
  logic           pul_we;

  // Ownership: the sample clock owns both buffers while playing.
  assign buf_raddr = play_i ? play_ptr : host_addr_i;
  assign pat_we    = host_wr_i & ~play_i & ~host_sel_i;
  assign pul_we    = host_wr_i & ~play_i &  host_sel_i;
  assign pat_slot  = play_i ? pat_rd : '0;

  emu_buf #(.W(SW), .DEPTH(DEPTH)) u_pat_buf (
    .clk_i  (clk_i),
    .we_i   (pat_we),
    .waddr_i(host_addr_i),
    .wdata_i(host_wdata_i),
    .raddr_i(buf_raddr),
    .rdata_o(pat_rd)
  );

  emu_buf #(.W(NCH), .DEPTH(DEPTH)) u_pul_buf (
    .clk_i  (clk_i),
    .we_i   (pul_we),
    .waddr_i(host_addr_i),
    .wdata_i(host_wdata_i[NCH-1:0]),
    .raddr_i(buf_raddr),
    .rdata_o(pul_rd)
  );

  emu_cnt #(.W(DW), .MAX(CNT_MAX_EVEN)) u_cnt_full (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_o (cnt_full)
  );

  emu_cnt #(.W(DW), .MAX(CNT_MAX_ODD)) u_cnt_half (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_o (cnt_half)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    localparam logic [11:0] FIX_C = (c % 2 == 0) ? FIX_EVEN : FIX_ODD;
    logic [DW-1:0] cnt_c;
    assign cnt_c = (c % 2 == 0) ? cnt_full : cnt_half;

    emu_chan_mux #(.DW(DW), .FIX(FIX_C)) u_mux (
      .sel_i (src_sel_i[2*c +: 2]),
      .live_i(adc_live_i[DW*c +: DW]),
      .pat_i (pat_slot[DW*c +: DW]),
      .cnt_i (cnt_c),
      .slot_o(sample_d[DW*c +: DW])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      play_ptr     <= '0;
      sample_o     <= '0;
      pulse_o      <= '0;
      host_rdata_o <= '0;
    end else begin
      if (!play_i)                          play_ptr <= '0;
      else if (play_ptr == AW'(DEPTH - 1))  play_ptr <= '0;
      else                                  play_ptr <= play_ptr + 1'b1;
      sample_o <= sample_d;
      pulse_o  <= play_i ? pul_rd : '0;
      if (host_rd_i && !play_i)
        host_rdata_o <= host_sel_i ? SW'(pul_rd) : pat_rd;
      else
        host_rdata_o <= '0;
    end
  end
endmodule

// File: rtl/adc_emu_chk.sv
module adc_emu_chk #(
  parameter int          NCH          = 8,
  parameter int          DW           = 12,
  parameter int          AW           = 9,
  parameter int          DEPTH        = 512,
  parameter logic [11:0] FIX_EVEN     = 12'h456,
  parameter int          CNT_MAX_EVEN = 4095
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               play_i,
  input logic               host_rd_i,
  input logic [1:0]         sel0_i,
  input logic [DW-1:0]      slot0_i,
  input logic [NCH-1:0]     pulse_i,
  input logic [NCH*DW-1:0]  rdata_i,
  input logic [AW-1:0]      ptr_i,
  input logic [DW-1:0]      cnt_i
);
  assert_play_rd_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (play_i && host_rd_i) |=> (rdata_i == '0));

  assert_idle_rdata_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_rd_i |=> (rdata_i == '0));

  assert_pulse_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !play_i |=> (pulse_i == '0));

  assert_ptr_home_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !play_i |=> (ptr_i == '0));

  assert_ptr_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (play_i && ptr_i != AW'(DEPTH - 1)) |=> (ptr_i == $past(ptr_i) + 1'b1));

  assert_ptr_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (play_i && ptr_i == AW'(DEPTH - 1)) |=> (ptr_i == '0));

  assert_fixed_slot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel0_i == 2'd2) |=> (slot0_i == DW'(FIX_EVEN)));

  assert_cnt_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == DW'(CNT_MAX_EVEN)) |=> (cnt_i == '0));

  assert_cnt_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != DW'(CNT_MAX_EVEN)) |=> (cnt_i == $past(cnt_i) + 1'b1));
endmodule

bind adc_emu_player adc_emu_chk #(
  .NCH(NCH), .DW(DW), .AW(AW), .DEPTH(DEPTH),
  .FIX_EVEN(FIX_EVEN), .CNT_MAX_EVEN(CNT_MAX_EVEN)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .play_i   (play_i),
  .host_rd_i(host_rd_i),
  .sel0_i   (src_sel_i[1:0]),
  .slot0_i  (sample_o[DW-1:0]),
  .pulse_i  (pulse_o),
  .rdata_i  (host_rdata_o),
  .ptr_i    (play_ptr),
  .cnt_i    (cnt_full)
);

// File: tb/sim_adc_emu_player.sv
module sim_adc_emu_player;
  localparam int NCH = 8, DW = 12, DEPTH = 512, AW = 9, SW = 96;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic play_i = 1'b0, host_wr_i = 1'b0, host_rd_i = 1'b0, host_sel_i = 1'b0;
  logic [AW-1:0] host_addr_i = '0;
  logic [SW-1:0] host_wdata_i = '0, adc_live_i = '0;
  logic [15:0]   src_sel_i = '0;
  logic [SW-1:0] host_rdata_o, sample_o;
  logic [NCH-1:0] pulse_o;

  always #2 clk_i = ~clk_i;

  adc_emu_player u0 (.*);

  typedef struct {
    logic [SW-1:0]  smp;
    logic [NCH-1:0] pul;
    logic [SW-1:0]  rd;
    string          tag;
  } item_t;

  item_t q[$];
  int checks = 0, fails = 0;

  // bench model
  logic [SW-1:0]  m_pat [DEPTH];
  logic [NCH-1:0] m_pul [DEPTH];
  int m_ptr = 0, m_cnt_e = 0, m_cnt_o = 0;

  task automatic step(input bit play, input bit wr, input bit rd, input bit sel,
                      input int addr, input logic [SW-1:0] wd,
                      input logic [15:0] ss, input logic [SW-1:0] live,
                      input string tag);
    item_t it;
    play_i = play; host_wr_i = wr; host_rd_i = rd; host_sel_i = sel;
    host_addr_i = AW'(addr); host_wdata_i = wd; src_sel_i = ss; adc_live_i = live;
    for (int c = 0; c < NCH; c++) begin
      logic [DW-1:0] v;
      case (ss[2*c +: 2])
        2'd0: v = live[DW*c +: DW];
        2'd1: v = play ? m_pat[m_ptr][DW*c +: DW] : '0;
        2'd2: v = (c % 2 == 0) ? 12'h456 : 12'hABC;
        default: v = (c % 2 == 0) ? DW'(m_cnt_e) : DW'(m_cnt_o);
      endcase
      it.smp[DW*c +: DW] = v;
    end
    it.pul = play ? m_pul[m_ptr] : '0;
    if (rd && !play) it.rd = sel ? SW'(m_pul[addr]) : m_pat[addr];
    else             it.rd = '0;
    it.tag = tag;
    q.push_back(it);
    if (wr && !play) begin
      if (sel) m_pul[addr] = wd[NCH-1:0];
      else     m_pat[addr] = wd;
    end
    m_ptr   = play ? ((m_ptr == DEPTH - 1) ? 0 : m_ptr + 1) : 0;
    m_cnt_e = (m_cnt_e == 4095) ? 0 : m_cnt_e + 1;
    m_cnt_o = (m_cnt_o == 2047) ? 0 : m_cnt_o + 1;
    @(negedge clk_i);
  endtask

  // monitor / scoreboard
  always @(posedge clk_i) begin
    #1;
    if (q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      checks++;
      if (sample_o !== e.smp || pulse_o !== e.pul || host_rdata_o !== e.rd) begin
        fails++;
        $display("FAIL %s: smp=%h pul=%h rd=%h expected smp=%h pul=%h rd=%h",
                 e.tag, sample_o, pulse_o, host_rdata_o, e.smp, e.pul, e.rd);
      end
    end
  end

  function automatic logic [SW-1:0] pat_word(input int a);
    logic [SW-1:0] w;
    for (int c = 0; c < NCH; c++) w[DW*c +: DW] = DW'(a * 3 + c * 257 + 1);
    return w;
  endfunction

  function automatic logic [SW-1:0] live_word(input int i);
    return {8{DW'(i * 5 + 12'h321)}};
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_pat[i] = '0; m_pul[i] = '0; end
    repeat (3) @(negedge clk_i);
    // R1: reset state
    checks++;
    if (sample_o !== '0) begin fails++; $display("FAIL R1: sample_o=%h expected 0", sample_o); end
    checks++;
    if (pulse_o !== '0) begin fails++; $display("FAIL R1: pulse_o=%h expected 0", pulse_o); end
    checks++;
    if (host_rdata_o !== '0) begin fails++; $display("FAIL R1: rdata=%h expected 0", host_rdata_o); end
    rst_ni = 1'b1;

    // R7 / R2: fill buffers while outputs follow live input
    for (int a = 0; a < DEPTH; a++)
      step(0, 1, 0, 0, a, pat_word(a), 16'h0000, live_word(a), "R7_R2_live");
    for (int a = 0; a < DEPTH; a++)
      step(0, 1, 0, 1, a, SW'((a * 37 + 11) & 8'hFF), 16'h0000, live_word(a + 7), "R7_pulse_fill");

    // R8: host read-back, and idle zero
    step(0, 0, 1, 0, 0,   '0, 16'h0, '0, "R8_read_pat0");
    step(0, 0, 1, 0, 511, '0, 16'h0, '0, "R8_read_pat511");
    step(0, 0, 1, 1, 3,   '0, 16'h0, '0, "R8_read_pul3");
    step(0, 0, 0, 0, 3,   '0, 16'h0, '0, "R8_idle_zero");

    // R9: host access during playout ignored
    step(1, 1, 1, 0, 5, {SW{1'b1}}, 16'h5555, '0, "R9_play_wr_pat");
    step(1, 1, 1, 1, 6, {SW{1'b1}}, 16'h5555, '0, "R9_play_wr_pul");
    step(0, 0, 1, 0, 5, '0, 16'h0, '0, "R9_pat_unchanged");
    step(0, 0, 1, 1, 6, '0, 16'h0, '0, "R9_pul_unchanged");

    // R5: playout with wrap past 511
    for (int i = 0; i < DEPTH + 20; i++)
      step(1, 0, 0, 0, 0, '0, 16'h5555, '0, "R5_playout");
    // R6: stop, pattern slots and pulses go to zero, index returns to 0
    step(0, 0, 0, 0, 0, '0, 16'h5555, '0, "R6_stop_zero");
    step(0, 0, 0, 0, 0, '0, 16'h5555, '0, "R6_stop_zero");
    for (int i = 0; i < 4; i++)
      step(1, 0, 0, 0, 0, '0, 16'h5555, '0, "R5_restart_at0");

    // R2 / R3 / R4: mixed per-channel select
    for (int i = 0; i < 8; i++)
      step(1, 0, 0, 0, 0, '0, 16'b11_10_01_00_00_01_10_11, live_word(i + 99), "R2_mixed");
    for (int i = 0; i < 4; i++)
      step(0, 0, 0, 0, 0, '0, 16'hAAAA, live_word(i), "R3_fixed");

    // R4: counters through both wraps
    for (int i = 0; i < 4200; i++)
      step(0, 0, 0, 0, 0, '0, 16'hFFFF, '0, "R4_counters");

    step(0, 0, 0, 0, 0, '0, 16'h0, '0, "R2_tail");
    repeat (2) @(negedge clk_i);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule